// File: doc/BRIEF.md
# Frequency Offset Acquisition Controller

This block pulls a local oscillator towards a reference by stepping a DAC tuning code. It searches in steps and is driven by measurements. A frequency counter outside the block reports the frequency difference as a two's-complement word with a valid strobe. The controller works on the magnitude of that word. After every code change it waits a programmable number of settling cycles. It then takes the next measurement and compares it with the one taken before the change. If the error grew, the search direction flips. The step is large while the error lies above a coarse threshold and small while it lies between the coarse and the fine threshold.

When a measurement falls at or below the fine threshold, the code is frozen. The controller raises the frequency-lock flag and enables the downstream phase-tracking loop filter. While locked it keeps watching the measurements. If a programmable number of consecutive measurements lie above the coarse threshold, it drops lock and resumes the search in coarse mode from the current code. The code never wraps. At either end of the DAC range it clamps and the search turns around.

Top module: `fa_acq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the tuning code to mid-scale (2^(CODE_W-1)), clears fine_mode, freq_lock and lf_enable, and sets the search direction to upward.
- R2: While enable is low, the tuning code holds its value, freq_lock, lf_enable and fine_mode are low, and measurements have no effect. Raising enable again starts a fresh settle period.
- R3: After each code update, and after enable rises or lock is released, the controller ignores meas_valid for settle_cycles+1 clock cycles. The first measurement it accepts is the first valid one after that period.
- R4: An accepted measurement whose magnitude is strictly greater than coarse_thr moves the code by coarse_step and leaves fine_mode low.
- R5: An accepted measurement whose magnitude is greater than fine_thr and at most coarse_thr moves the code by fine_step and sets fine_mode high.
- R6: When the magnitude of an accepted measurement is strictly greater than that of the previous accepted measurement in the same search, the direction flips before the step is applied. The first step after reset, enable or unlock goes in the stored direction, which is upward.
- R7: A step that would pass the maximum code (2^CODE_W-1) or go below zero clamps at that end and reverses the direction.
- R8: An accepted measurement whose magnitude is at most fine_thr sets freq_lock and fine_mode and freezes the tuning code for as long as lock holds.
- R9: lf_enable equals freq_lock in every cycle.
- R10: While locked, lock is released when unlock_count consecutive valid measurements exceed coarse_thr (0 acts as 1). A measurement at or below coarse_thr clears the run. Release clears fine_mode.
- R11: meas_err is two's complement. A negative difference is judged by its magnitude, exactly like the positive difference of the same size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the search when high |
| meas_valid | input | 1 | Strobe for meas_err |
| meas_err | input | ERR_W | Measured frequency difference, two's complement |
| coarse_thr | input | ERR_W | Boundary between the large-step and small-step regions |
| fine_thr | input | ERR_W | Lock boundary |
| coarse_step | input | CODE_W | Large step size |
| fine_step | input | CODE_W | Small step size |
| settle_cycles | input | SETTLE_W | Settling wait after a code change |
| unlock_count | input | MISS_W | Consecutive out-of-range measurements that release lock |
| tune_code | output | CODE_W | DAC tuning code |
| fine_mode | output | 1 | High in the small-step region and while locked |
| freq_lock | output | 1 | Frequency lock flag |
| lf_enable | output | 1 | Enable for the phase-tracking loop filter |

## Verification
Two corrections can land on the same update: a turn caused by a growing error and a clamp at the end of the range. The first flips the direction and the second flips it back. The bench provokes this by placing the target beyond either end of the DAC range. The search then runs into the end, sees its error grow on the way back and turns again, in both directions. A behavioural model steps through the same rules in order: magnitude, turn on growth, then clamp. The bench compares the code, the mode and the lock outputs with that model on every clock, so a wrong order of the two corrections shows up at once as a code mismatch.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_MEAS   = 2'd2,
    ST_LOCK   = 2'd3
  } fa_state_e;
endpackage

// File: rtl/fa_magnitude.sv
module fa_magnitude #(
  parameter int ERR_W      = 16,
  parameter bit SIGNED_ERR = 1'b1
) (
  input  logic [ERR_W-1:0] err,
  output logic [ERR_W-1:0] mag
);
  localparam logic [ERR_W-1:0] ONE = ERR_W'(1);

  generate
    if (SIGNED_ERR) begin : g_signed
      always_comb mag = err[ERR_W-1] ? (~err + ONE) : err;
    end else begin : g_unsigned
      always_comb mag = err;
    end
  endgenerate
endmodule

// File: rtl/fa_step_calc.sv
module fa_step_calc #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] code,
  input  logic              dir_up,
  input  logic [CODE_W-1:0] step,
  output logic [CODE_W-1:0] nxt_code,
  output logic              nxt_dir_up
);
  localparam logic [CODE_W:0]   TOP  = {1'b0, {CODE_W{1'b1}}};
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

  logic [CODE_W:0] sum;

  always_comb begin
    sum = {1'b0, code} + {1'b0, step};
    if (dir_up) begin
      if (sum > TOP) begin
        nxt_code   = MAXC;
        nxt_dir_up = 1'b0;
      end else begin
        nxt_code   = sum[CODE_W-1:0];
        nxt_dir_up = 1'b1;
      end
    end else begin
      if (code < step) begin
        nxt_code   = '0;
        nxt_dir_up = 1'b1;
      end else begin
        nxt_code   = code - step;
        nxt_dir_up = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fa_settle_timer.sv
module fa_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                done
);
  localparam logic [SETTLE_W-1:0] ONE = SETTLE_W'(1);

  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign done = (cnt == '0);

  // R3: a loaded count runs down one per cycle and never wraps
  assert_settle_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
  assert_settle_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/fa_acq_ctrl.sv
module fa_acq_ctrl
  import fa_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int ERR_W      = 16,
  parameter int SETTLE_W   = 8,
  parameter int MISS_W     = 4,
  parameter bit SIGNED_ERR = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                meas_valid,
  input  logic [ERR_W-1:0]    meas_err,
  input  logic [ERR_W-1:0]    coarse_thr,
  input  logic [ERR_W-1:0]    fine_thr,
  input  logic [CODE_W-1:0]   coarse_step,
  input  logic [CODE_W-1:0]   fine_step,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [MISS_W-1:0]   unlock_count,
  output logic [CODE_W-1:0]   tune_code,
  output logic                fine_mode,
  output logic                freq_lock,
  output logic                lf_enable
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [MISS_W:0]   MISS_ONE = (MISS_W + 1)'(1);

  fa_state_e         state;
  logic              dir_up;
  logic [ERR_W-1:0]  prev_mag;
  logic              have_prev;
  logic [MISS_W-1:0] miss_cnt;

  logic [ERR_W-1:0]  mag;
  logic              over_coarse, in_fine, grew, dir_eff, miss_hit;
  logic [CODE_W-1:0] step_sel, nxt_code;
  logic              nxt_dir_up;
  logic              settle_done, settle_load;

  fa_magnitude #(.ERR_W(ERR_W), .SIGNED_ERR(SIGNED_ERR)) u_mag (
    .err (meas_err),
    .mag (mag)
  );

  always_comb begin
    over_coarse = (mag > coarse_thr);
    in_fine     = (mag <= fine_thr);
    grew        = have_prev && (mag > prev_mag);
    dir_eff     = dir_up ^ grew;
    step_sel    = over_coarse ? coarse_step : fine_step;
    miss_hit    = ({1'b0, miss_cnt} + MISS_ONE) >= {1'b0, unlock_count};
  end

  fa_step_calc #(.CODE_W(CODE_W)) u_step (
    .code       (tune_code),
    .dir_up     (dir_eff),
    .step       (step_sel),
    .nxt_code   (nxt_code),
    .nxt_dir_up (nxt_dir_up)
  );

  always_comb begin
    settle_load = 1'b0;
    if (enable) begin
      unique case (state)
        ST_IDLE: settle_load = 1'b1;
        ST_MEAS: settle_load = meas_valid && !in_fine;
        ST_LOCK: settle_load = meas_valid && over_coarse && miss_hit;
        default: settle_load = 1'b0;
      endcase
    end
  end

  fa_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .load     (settle_load),
    .load_val (settle_cycles),
    .done     (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tune_code <= MID_CODE;
      fine_mode <= 1'b0;
      freq_lock <= 1'b0;
      lf_enable <= 1'b0;
      dir_up    <= 1'b1;
      prev_mag  <= '0;
      have_prev <= 1'b0;
      miss_cnt  <= '0;
    end else if (!enable) begin
      state     <= ST_IDLE;
      fine_mode <= 1'b0;
      freq_lock <= 1'b0;
      lf_enable <= 1'b0;
      dir_up    <= 1'b1;
      have_prev <= 1'b0;
      miss_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_SETTLE;
        ST_SETTLE: if (settle_done) state <= ST_MEAS;
        ST_MEAS: begin
          if (meas_valid) begin
            if (in_fine) begin
              state     <= ST_LOCK;
              freq_lock <= 1'b1;
              lf_enable <= 1'b1;
              fine_mode <= 1'b1;
              miss_cnt  <= '0;
            end else begin
              state     <= ST_SETTLE;
              tune_code <= nxt_code;
              dir_up    <= nxt_dir_up;
              fine_mode <= !over_coarse;
              prev_mag  <= mag;
              have_prev <= 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (meas_valid) begin
            if (over_coarse) begin
              if (miss_hit) begin
                state     <= ST_SETTLE;
                freq_lock <= 1'b0;
                lf_enable <= 1'b0;
                fine_mode <= 1'b0;
                have_prev <= 1'b0;
                miss_cnt  <= '0;
              end else begin
                miss_cnt  <= miss_cnt + 1'b1;
              end
            end else begin
              miss_cnt <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: loop filter enable mirrors the lock flag
  assert_lf_tracks_lock_R9: assert property (@(posedge clk) disable iff (rst)
    lf_enable == freq_lock);

  // R2: with enable low the next cycle is unlocked, coarse and holds the code
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!freq_lock && !fine_mode && $stable(tune_code)));

  // R3: the code changes only right after an accepted measurement
  assert_code_moves_on_meas_R3: assert property (@(posedge clk) disable iff (rst)
    (tune_code != $past(tune_code)) |-> ($past(state) == ST_MEAS && $past(meas_valid)));

  // R8: code frozen while locked, and lock implies fine mode
  assert_lock_freezes_code_R8: assert property (@(posedge clk) disable iff (rst)
    freq_lock |=> $stable(tune_code));
  assert_lock_in_fine_R8: assert property (@(posedge clk) disable iff (rst)
    freq_lock |-> fine_mode);

  // R7: no wrap, a code change is never larger than a configured step
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (tune_code != $past(tune_code)) |->
      ((tune_code > $past(tune_code) ? tune_code - $past(tune_code)
                                     : $past(tune_code) - tune_code)
       <= ($past(coarse_step) > $past(fine_step) ? $past(coarse_step) : $past(fine_step))));
endmodule

// File: tb/sim_fa_acq_ctrl.sv
`timescale 1ns/1ps
module sim_fa_acq_ctrl;
  localparam int CODE_W = 12, ERR_W = 16, SETTLE_W = 8, MISS_W = 4;
  localparam int MAXC = (1 << CODE_W) - 1;
  localparam int MID  = 1 << (CODE_W - 1);
  localparam int GAIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic meas_valid = 1'b0;
  logic [ERR_W-1:0]    meas_err = '0;
  logic [ERR_W-1:0]    coarse_thr = 16'd400;
  logic [ERR_W-1:0]    fine_thr = 16'd12;
  logic [CODE_W-1:0]   coarse_step = 12'd64;
  logic [CODE_W-1:0]   fine_step = 12'd4;
  logic [SETTLE_W-1:0] settle_cycles = 8'd3;
  logic [MISS_W-1:0]   unlock_count = 4'd3;
  logic [CODE_W-1:0]   tune_code;
  logic fine_mode, freq_lock, lf_enable;

  always #2 clk = ~clk;

  fa_acq_ctrl #(.CODE_W(CODE_W), .ERR_W(ERR_W), .SETTLE_W(SETTLE_W), .MISS_W(MISS_W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .meas_valid(meas_valid), .meas_err(meas_err),
    .coarse_thr(coarse_thr), .fine_thr(fine_thr), .coarse_step(coarse_step),
    .fine_step(fine_step), .settle_cycles(settle_cycles), .unlock_count(unlock_count),
    .tune_code(tune_code), .fine_mode(fine_mode), .freq_lock(freq_lock), .lf_enable(lf_enable));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int target = MID;
  bit manual = 1'b0;
  bit started = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int max_seen = 0, min_seen = MAXC;

  // behavioural reference: 0 idle, 1 settle, 2 measure, 3 locked
  int m_code = MID, m_fine = 0, m_lock = 0, m_state = 0, m_cnt = 0;
  int m_dirup = 1, m_prev = 0, m_have = 0, m_miss = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    int mag, step, e;
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    started = 1'b1;
    e = int'($signed(meas_err));
    mag = (e < 0) ? -e : e;   // R11
    if (rst) begin
      m_code = MID; m_fine = 0; m_lock = 0; m_state = 0; m_dirup = 1;
      m_prev = 0; m_have = 0; m_miss = 0; m_cnt = 0;
    end else if (!enable) begin
      m_state = 0; m_lock = 0; m_fine = 0; m_have = 0; m_miss = 0; m_dirup = 1;
    end else begin
      case (m_state)
        0: begin m_state = 1; m_cnt = int'(settle_cycles); end
        1: if (m_cnt == 0) m_state = 2; else m_cnt--;
        2: if (meas_valid) begin
          if (mag <= int'(fine_thr)) begin
            m_state = 3; m_lock = 1; m_fine = 1; m_miss = 0;
          end else begin
            step = (mag > int'(coarse_thr)) ? int'(coarse_step) : int'(fine_step);
            if (m_have != 0 && mag > m_prev) m_dirup = 1 - m_dirup;
            if (m_dirup != 0) begin
              if (m_code + step > MAXC) begin m_code = MAXC; m_dirup = 0; end
              else m_code = m_code + step;
            end else begin
              if (m_code < step) begin m_code = 0; m_dirup = 1; end
              else m_code = m_code - step;
            end
            m_fine = (mag <= int'(coarse_thr)) ? 1 : 0;
            m_prev = mag; m_have = 1; m_state = 1; m_cnt = int'(settle_cycles);
          end
        end
        3: if (meas_valid) begin
          if (mag > int'(coarse_thr)) begin
            if (m_miss + 1 >= int'(unlock_count)) begin
              m_lock = 0; m_fine = 0; m_have = 0; m_miss = 0;
              m_state = 1; m_cnt = int'(settle_cycles);
            end else m_miss++;
          end else m_miss = 0;
        end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(tune_code === CODE_W'(m_code), "R3 R4 R5 R6 R7 R11 tune_code", int'(tune_code), m_code);
      check(fine_mode === m_fine[0], "R4 R5 R10 fine_mode", int'(fine_mode), m_fine);
      check(freq_lock === m_lock[0], "R8 R10 freq_lock", int'(freq_lock), m_lock);
      check(lf_enable === freq_lock, "R9 lf_enable", int'(lf_enable), int'(freq_lock));
      if (int'(tune_code) > max_seen) max_seen = int'(tune_code);
      if (int'(tune_code) < min_seen) min_seen = int'(tune_code);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!manual) begin
      meas_valid = (lfsr[1:0] != 2'b00);
      meas_err = 16'((m_code - target) * GAIN);
    end
  end

  task automatic run_until_lock(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (freq_lock) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tune_code == 12'd2048, "R1 reset code", int'(tune_code), MID);
    check(!fine_mode && !freq_lock && !lf_enable, "R1 reset flags",
          int'({fine_mode, freq_lock, lf_enable}), 0);

    // enable low: measurements ignored
    target = 100;
    repeat (20) @(negedge clk);
    check(tune_code == 12'd2048, "R2 code held while disabled", int'(tune_code), MID);

    // search upward from mid-scale, error negative (R11)
    target = MID + 700;
    enable = 1'b1;
    run_until_lock(4000);
    check(freq_lock == 1'b1, "R8 lock reached", int'(freq_lock), 1);
    check(((int'(tune_code) - target) * GAIN <= 12) && ((target - int'(tune_code)) * GAIN <= 12),
          "R8 inside fine window", int'(tune_code), target);

    // lock hysteresis: two misses, a good one, then three misses
    manual = 1'b1;
    meas_valid = 1'b1; meas_err = 16'd1000;
    @(negedge clk); meas_err = 16'd1000;
    @(negedge clk); meas_err = 16'd0;
    @(negedge clk); meas_err = 16'hFC18;  // -1000
    check(freq_lock == 1'b1, "R10 non-consecutive misses keep lock", int'(freq_lock), 1);
    @(negedge clk); meas_err = 16'd1000;
    @(negedge clk); meas_err = 16'd1000;
    check(freq_lock == 1'b1, "R10 two misses keep lock", int'(freq_lock), 1);
    @(negedge clk);
    check(freq_lock == 1'b0 && fine_mode == 1'b0, "R10 third miss releases lock",
          int'({freq_lock, fine_mode}), 0);
    manual = 1'b0;

    // target past the top end: clamp and turn (R7 with R6)
    target = 5000;
    repeat (3000) @(negedge clk);
    check(max_seen == MAXC, "R7 top clamp reached", max_seen, MAXC);

    // drop enable mid-search
    enable = 1'b0;
    repeat (6) @(negedge clk);
    check(!freq_lock && !fine_mode, "R2 disabled mid-search", int'({freq_lock, fine_mode}), 0);
    enable = 1'b1;

    // target below zero: bottom clamp
    target = -500;
    repeat (3000) @(negedge clk);
    check(min_seen == 0, "R7 bottom clamp reached", min_seen, 0);

    // re-acquire a low target, with a longer settle time
    settle_cycles = 8'd7;
    target = 300;
    run_until_lock(6000);
    check(freq_lock == 1'b1, "R8 relock low target", int'(freq_lock), 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule